// File: doc/BRIEF.md
# Burst Streaming Write Master

This block turns block-transfer commands into burst writes on a memory-mapped bus. A controller hands it a byte address and a byte count over a valid/ready command port. A pattern source supplies the data words over a separate valid/ready data port. The block splits each block into bursts of at most `MAX_BURST` beats. A burst never crosses an address boundary that is a multiple of `MAX_BURST` words, so a start that is not on such a boundary begins with a shorter burst until the address is aligned.

A small internal word buffer holds data ahead of the bus. A burst is launched only once every word it needs is already held in that buffer, so once started it never has to wait for data. When the last beat of a block has been accepted, a one-cycle completion pulse is raised, and the command port reopens on the following cycle.

Top module: `burst_write_master`

## Requirements
- R1: After reset `cmd_ready` is 1, and `mem_write` and `blk_done` are 0. `cmd_ready` is high only while no block is in progress, and a command is taken on a cycle where `cmd_valid` and `cmd_ready` are both 1.
- R2: `mem_burst` is between 1 and `MAX_BURST` on every cycle where `mem_write` is 1.
- R3: Take the word index as `mem_addr >> log2(DATA_W/8)`. Then (word index mod `MAX_BURST`) + `mem_burst` never exceeds `MAX_BURST`.
- R4: A block that starts on a word index that is not a multiple of `MAX_BURST` first issues a burst of `MAX_BURST` minus (index mod `MAX_BURST`) beats. With the default of 2, that first burst is one beat.
- R5: A block of N words, where N = `cmd_bytes` >> log2(DATA_W/8), produces exactly N accepted beats. Each burst is the smaller of the words remaining and the room left to the next aligned boundary, so the final burst is cut to the words that remain.
- R6: While `mem_write` and `mem_wait` are both 1, the next cycle keeps `mem_write` high and holds `mem_addr`, `mem_burst` and `mem_wdata` unchanged.
- R7: When a burst's first beat appears, the number of words accepted on the data port but not yet written is at least `mem_burst`.
- R8: `din_ready` is 0 on every cycle where `mem_write` and `mem_wait` are both 1.
- R9: `blk_done` is high for exactly one cycle, in the cycle after the block's last beat is accepted. `cmd_ready` returns to 1 in the cycle after that.
- R10: Beat k of a block (counting from 0) carries the k-th word accepted for that block. Its byte address, which is the burst address plus 4 times the beat's position in the burst, equals the command address plus k times the word size.
- R11: A command whose byte count is below one word performs no write and still raises `blk_done` once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Idle; able to take a command |
| cmd_addr | input | ADDR_W | Block start byte address, word aligned |
| cmd_bytes | input | LEN_W | Block length in bytes |
| din_valid | input | 1 | Data word offered |
| din_ready | output | 1 | Data word accepted this cycle if valid |
| din_data | input | DATA_W | Data word |
| mem_addr | output | ADDR_W | Burst start byte address |
| mem_write | output | 1 | Write beat request |
| mem_wdata | output | DATA_W | Write beat data |
| mem_burst | output | BC_W | Beats in the current burst |
| mem_wait | input | 1 | Slave stall; the beat is not taken |
| blk_done | output | 1 | One-cycle block completion pulse |

## Verification
A wrong remaining-word count or a wrong address register shows up on the bus within one burst. The result is a burst length that disagrees with the alignment model, a beat address off the expected sequence, or a `blk_done` pulse that comes early, late or not at all. A wrong buffer count shows up as one of two faults: a burst that starts before its data has arrived, which the accepted-minus-written balance catches at the first beat, or a beat carrying the wrong word. Faulty stall handling shows up in the stalled cycle itself or the cycle after it, either as a data word accepted during the stall or as bus fields that change while the slave is still stalling.

// File: rtl/burst_write_master.sv
module burst_write_master #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 2,
  localparam int BSH  = $clog2(DATA_W/8),
  localparam int MSH  = $clog2(MAX_BURST),
  localparam int BC_W = $clog2(MAX_BURST) + 1,
  localparam int FC_W = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_bytes,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [DATA_W-1:0] din_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_write,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [BC_W-1:0]   mem_burst,
  input  logic              mem_wait,
  output logic              blk_done
);

  typedef enum logic [1:0] {S_IDLE, S_PLAN, S_BURST, S_DONE} state_t;

  state_t             state;
  logic [ADDR_W-1:0]  addr_q;
  logic [LEN_W-1:0]   words_q;
  logic [BC_W-1:0]    len_q;
  logic [BC_W-1:0]    beat_q;

  logic [DATA_W-1:0]  buf_mem [MAX_BURST];
  logic [MSH-1:0]     wp, rp;
  logic [FC_W-1:0]    fcnt;

  logic [MSH-1:0]     align;
  logic [BC_W-1:0]    room, next_len;
  logic               push, pop, start, last_beat;
  logic [LEN_W-1:0]   cmd_words;

  assign cmd_ready = (state == S_IDLE);
  assign blk_done  = (state == S_DONE);
  assign mem_write = (state == S_BURST);
  assign mem_addr  = addr_q;
  assign mem_burst = len_q;
  assign mem_wdata = buf_mem[rp];

  assign din_ready = (fcnt != FC_W'(MAX_BURST)) && !(mem_write && mem_wait);
  assign push      = din_valid && din_ready;
  assign pop       = mem_write && !mem_wait;

  assign align     = addr_q[BSH +: MSH];
  assign room      = BC_W'(MAX_BURST) - BC_W'(align);
  assign next_len  = (words_q < LEN_W'(room)) ? BC_W'(words_q) : room;
  assign start     = (state == S_PLAN) && (FC_W'(next_len) <= fcnt);
  assign last_beat = pop && (beat_q == len_q - 1'b1);
  assign cmd_words = cmd_bytes >> BSH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fcnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      fcnt <= fcnt + FC_W'(push) - FC_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) buf_mem[wp] <= din_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      words_q <= '0;
      len_q   <= BC_W'(1);
      beat_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          addr_q  <= {cmd_addr[ADDR_W-1:BSH], {BSH{1'b0}}};
          words_q <= cmd_words;
          state   <= (cmd_words == '0) ? S_DONE : S_PLAN;
        end
        S_PLAN: if (start) begin
          len_q  <= next_len;
          beat_q <= '0;
          state  <= S_BURST;
        end
        S_BURST: if (pop) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            addr_q  <= addr_q + (ADDR_W'(len_q) << BSH);
            words_q <= words_q - LEN_W'(len_q);
            state   <= (words_q == LEN_W'(len_q)) ? S_DONE : S_PLAN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module burst_write_master_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BURST = 2,
  localparam int BSH  = $clog2(DATA_W/8),
  localparam int MSH  = $clog2(MAX_BURST),
  localparam int BC_W = $clog2(MAX_BURST) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              din_valid,
  input logic              din_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_write,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [BC_W-1:0]   mem_burst,
  input logic              mem_wait,
  input logic              blk_done
);
  logic [7:0]      held;
  logic [BC_W-1:0] beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      beat <= '0;
    end else begin
      held <= held + 8'(din_valid && din_ready) - 8'(mem_write && !mem_wait);
      if (mem_write && !mem_wait)
        beat <= (beat + 1'b1 == mem_burst) ? '0 : beat + 1'b1;
    end
  end

  AST_BURST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_write |-> (mem_burst >= 1 && mem_burst <= BC_W'(MAX_BURST)));  // R2
  AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_write |-> (BC_W'(mem_addr[BSH +: MSH]) + mem_burst <= BC_W'(MAX_BURST)));  // R3
  AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_write && mem_wait) |=> (mem_write && $stable(mem_addr) && $stable(mem_burst) && $stable(mem_wdata)));  // R6
  AST_DATA_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_write && beat == '0) |-> (held >= 8'(mem_burst)));  // R7
  AST_STALL_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_write && mem_wait) |-> !din_ready);  // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);  // R9
endmodule

bind burst_write_master burst_write_master_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAX_BURST)
) chk_i (
  .clk(clk), .rst_n(rst_n), .din_valid(din_valid), .din_ready(din_ready),
  .mem_addr(mem_addr), .mem_write(mem_write), .mem_wdata(mem_wdata),
  .mem_burst(mem_burst), .mem_wait(mem_wait), .blk_done(blk_done)
);

// File: tb/burst_write_master_tb_top.sv
module burst_write_master_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [15:0] cmd_bytes = '0;
  logic        din_valid = 0;
  logic        din_ready;
  logic [31:0] din_data = '0;
  logic [31:0] mem_addr;
  logic        mem_write;
  logic [31:0] mem_wdata;
  logic [1:0]  mem_burst;
  logic        mem_wait = 0;
  logic        blk_done;

  int n_chk = 0;
  int n_bad = 0;
  int base_val = 32'h1000;

  always #5 clk = ~clk;

  burst_write_master dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .din_valid(din_valid),
    .din_ready(din_ready), .din_data(din_data), .mem_addr(mem_addr),
    .mem_write(mem_write), .mem_wdata(mem_wdata), .mem_burst(mem_burst),
    .mem_wait(mem_wait), .blk_done(blk_done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(cmd_ready == 1, "R1 reset cmd_ready", cmd_ready, 1);
    chk(mem_write == 0, "R1 reset mem_write", mem_write, 0);
    chk(blk_done == 0,  "R1 reset blk_done", blk_done, 0);
  endtask

  // wmode: 0 no stalls, 1 stall every third cycle; gap: data offered every gap cycles
  task automatic run_cmd(input int addr, input int bytes, input int wmode, input int gap);
    int nw = bytes >> 2;
    int fed = 0, wr = 0, beat = 0, dones = 0, bursts = 0;
    bit in_b = 0, accepted = 0, done_prev = 0, p_stall = 0, finished = 0;
    logic [31:0] p_addr, p_data;
    logic [1:0]  p_bc;
    @(negedge clk);
    cmd_addr = addr; cmd_bytes = bytes; cmd_valid = 1;
    for (int cyc = 0; cyc < 3000 && !finished; cyc++) begin
      if (cyc != 0) @(negedge clk);
      if (accepted) cmd_valid = 0;
      mem_wait  = (wmode == 1) && (cyc % 3 == 0);
      din_valid = (fed < nw) && (cyc % gap == 0);
      din_data  = base_val + fed;
      #1;
      if (done_prev) begin
        chk(cmd_ready == 1, "R9 cmd_ready after done", cmd_ready, 1);
        chk(blk_done == 0, "R9 done single cycle", blk_done, 0);
        finished = 1;
      end else begin
        if (accepted) chk(cmd_ready == 0 || blk_done, "R1 busy cmd_ready", cmd_ready, 0);
        if (p_stall) begin
          chk(mem_write && mem_addr == p_addr && mem_burst == p_bc && mem_wdata == p_data,
              "R6 hold under wait", mem_addr, p_addr);
        end
        p_stall = mem_write && mem_wait;
        p_addr = mem_addr; p_bc = mem_burst; p_data = mem_wdata;
        if (mem_write && mem_wait) chk(din_ready == 0, "R8 backpressure", din_ready, 0);
        if (mem_write && !in_b) begin
          int wi = (addr >> 2) + wr;
          int room = 2 - (wi % 2);
          int exp = (nw - wr < room) ? nw - wr : room;
          in_b = 1; beat = 0; bursts++;
          chk(mem_burst == exp, bursts == 1 ? "R4 first burst length" : "R5 burst length", mem_burst, exp);
          chk(((mem_addr >> 2) % 2) + mem_burst <= 2, "R3 no boundary cross", mem_addr, addr + 4*wr);
          chk(fed - wr >= mem_burst, "R7 data held before burst", fed - wr, mem_burst);
        end
        if (mem_write && !mem_wait) begin
          chk(mem_addr + 4*beat == addr + 4*wr, "R10 beat address", mem_addr + 4*beat, addr + 4*wr);
          chk(mem_wdata == base_val + wr, "R10 beat data", mem_wdata, base_val + wr);
          wr++; beat++;
          if (beat == mem_burst) in_b = 0;
        end
        if (blk_done) begin
          dones++;
          chk(wr == nw, "R5 beats before done", wr, nw);
          chk(!in_b, "R9 done after last beat", in_b, 0);
          done_prev = 1;
        end
        if (din_valid && din_ready) fed++;
        if (cmd_valid && cmd_ready) accepted = 1;
      end
    end
    chk(finished, "R9 block completed", finished, 1);
    chk(dones == 1, nw == 0 ? "R11 zero-length done" : "R9 done count", dones, 1);
    chk(wr == nw, nw == 0 ? "R11 no write" : "R5 total beats", wr, nw);
    base_val += nw;
    mem_wait = 0; din_valid = 0; cmd_valid = 0;
  endtask

  task automatic t_aligned();      run_cmd(32'h100, 32, 0, 1); endtask
  task automatic t_unaligned();    run_cmd(32'h204, 20, 0, 1); endtask
  task automatic t_single_odd();   run_cmd(32'h30C, 4,  0, 1); endtask
  task automatic t_short_tail();   run_cmd(32'h400, 12, 0, 1); endtask
  task automatic t_stalls();       run_cmd(32'h504, 28, 1, 1); endtask
  task automatic t_slow_data();    run_cmd(32'h600, 24, 0, 4); endtask
  task automatic t_slow_stall();   run_cmd(32'h714, 36, 1, 3); endtask
  task automatic t_zero();         run_cmd(32'h800, 0,  0, 1); endtask
  task automatic t_sub_word();     run_cmd(32'h900, 3,  0, 1); endtask

  initial begin
    t_reset();
    t_aligned();
    t_unaligned();
    t_single_odd();
    t_short_tail();
    t_stalls();
    t_slow_data();
    t_slow_stall();
    t_zero();
    t_sub_word();
    t_aligned();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule